// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Controller

This controller runs a fast successive-approximation converter that has a serial output. Each conversion begins with a start pulse of fixed width. The controller then waits for the most significant bit to settle, and after that it sends a burst of serial clocks to shift the result in, MSB first. All of these intervals are counted in system-clock cycles and set through parameters. A parameter combination that cannot work is refused at elaboration.

The readout has two modes. In returned-clock mode the converter sends back a delayed copy of each serial clock. The controller passes that copy and the data line through a two-flop synchronizer, then samples the data on each synchronized rising edge. Sixteen bits make one result. In own-clock mode the controller samples the data line in the same cycle that it drives the serial clock low. It reads eighteen bits. The first two bits are a fixed header and are not part of the result.

The start strobes are spaced by at least a minimum period. A request that arrives early is held until that period has passed. Once the readout has begun, a new conversion can start while the previous result is still being clocked out. If the gap since the previous strobe is longer than the maximum idle time, the new conversion's result is marked invalid. Each result is delivered as one 16-bit word with a single-cycle valid pulse and an invalid flag.

Top module: `sar_read_ctrl`

## Requirements
- R1: After reset the strobe, serial clock, result word, valid pulse and invalid flag are all 0.
- R2: Every conversion strobe stays high for exactly CNV_HIGH_CYC cycles (2 by default).
- R3: Two rising edges of the strobe are never closer than MIN_PERIOD_CYC cycles (76 by default). A request made earlier is held and launches in exactly the cycle the period ends.
- R4: The first serial-clock rise of a readout comes exactly MSB_WAIT_CYC cycles (10) after the rising edge of its strobe.
- R5: The serial clock is high and low for SCLK_HALF_CYC cycles each. It gives 16 rising edges per readout in returned-clock mode (mode input 0) and 18 in own-clock mode (mode input 1). It is low whenever no readout is active.
- R6: In returned-clock mode the result word holds the 16 bits sampled on the synchronized returned-clock rising edges. The first bit received is bit 15.
- R7: In own-clock mode the first two bits received form a header, first bit in bit 1. If the header differs from HDR_PATTERN (2'b10 by default), the result is invalid. The remaining 16 bits form the word, MSB first.
- R8: A conversion whose strobe rise comes more than MAX_IDLE_CYC cycles (1000) after the previous strobe rise gets an invalid result. So does the first conversion after reset. A spacing of exactly MAX_IDLE_CYC still gives a valid result.
- R9: Each readout ends with a valid pulse one cycle long. The word and the invalid flag hold their values between pulses.
- R10: The mode input is taken only while the controller is idle, meaning no strobe, no pending read and no readout. A change during a conversion or readout does not affect that readout.
- R11: A request made during a readout can launch the next strobe before the current readout finishes. Both results are still delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request pulse |
| modeSel | input | 1 | Read mode: 0 returned-clock, 1 own-clock |
| sdataIn | input | 1 | Serial data from the converter |
| echoClkIn | input | 1 | Returned copy of the serial clock |
| cnvOut | output | 1 | Conversion-start strobe |
| sclkOut | output | 1 | Serial read clock |
| resultWord | output | 16 | Last assembled result |
| resultValid | output | 1 | One-cycle pulse when a new result is ready |
| resultInvalid | output | 1 | Result is stale or has a bad header |

## Verification
The case that is hardest to reach from the ports is the overlap. A strobe must rise while an own-clock burst is still shifting, and both results must still come out correct. The stimulus reaches it by timing an own-clock request to land exactly one minimum period after the previous strobe. At that spacing the 18-bit burst is still running when the strobe rises. Stale-flag boundaries are hit the same way: requests are placed at spacings of exactly the idle limit and one cycle past it. A modelled converter returns the clock with a real delay, so the synchronizer path is exercised with a true lag.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  localparam int WORD_W     = 16;
  localparam int ECHO_BITS  = 16;
  localparam int SELF_BITS  = 18;
  localparam int HDR_W      = SELF_BITS - WORD_W;

  // Strobes from the conversion sequencer to the readout datapath
  typedef struct packed {
    logic readGo;    // start a readout burst this cycle
    logic selfMode;  // readout uses own-clock sampling
    logic stale;     // conversion came after too long an idle gap
  } rdStrobeT;
endpackage

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int CNV_HIGH_CYC   = 2,
  parameter int MSB_WAIT_CYC   = 10,
  parameter int MIN_PERIOD_CYC = 76,
  parameter int MAX_IDLE_CYC   = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startReq,
  input  logic     modeSel,
  input  logic     readerBusy,
  output logic     cnvOut,
  output rdStrobeT ctl
);
  localparam int GAP_W = $clog2(MAX_IDLE_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX   = GAP_W'(MAX_IDLE_CYC);
  localparam logic [GAP_W-1:0] GAP_LAUNCH = GAP_W'(MIN_PERIOD_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_CNVEND = GAP_W'(CNV_HIGH_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_READ  = GAP_W'(MSB_WAIT_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_IDLE  = GAP_W'(MSB_WAIT_CYC);
  localparam logic [GAP_W-1:0] GAP_CNVHI = GAP_W'(CNV_HIGH_CYC);

  logic [GAP_W-1:0] gapCnt;   // cycles since last strobe rise, saturating
  logic pending;
  logic cnvReg;
  logic modeReg;
  logic staleReg;
  logic launch;
  logic ctlIdle;

  assign launch  = (startReq || pending) && (gapCnt >= GAP_LAUNCH);
  assign ctlIdle = !cnvReg && !pending && !readerBusy && (gapCnt >= GAP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt   <= GAP_MAX;     // reset counts as a long idle gap
      pending  <= 1'b0;
      cnvReg   <= 1'b0;
      modeReg  <= 1'b0;
      staleReg <= 1'b0;
    end else begin
      if (ctlIdle) modeReg <= modeSel;
      if (launch) begin
        gapCnt   <= '0;
        staleReg <= (gapCnt >= GAP_MAX);
        cnvReg   <= 1'b1;
        pending  <= 1'b0;
      end else begin
        if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
        if (cnvReg && gapCnt == GAP_CNVEND) cnvReg <= 1'b0;
        if (startReq) pending <= 1'b1;
      end
    end
  end

  assign cnvOut       = cnvReg;
  assign ctl.readGo   = (gapCnt == GAP_READ);
  assign ctl.selfMode = modeReg;
  assign ctl.stale    = staleReg;

  AST_CNV_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    cnvReg |-> (gapCnt < GAP_CNVHI)); // R2

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (readerBusy || cnvReg || pending) |=> $stable(modeReg)); // R10
endmodule

// File: rtl/sar_rd_shift.sv
module sar_rd_shift
  import sar_rd_pkg::*;
#(
  parameter int                 SCLK_HALF_CYC = 2,
  parameter logic [HDR_W-1:0]   HDR_PATTERN   = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdStrobeT          ctl,
  input  logic              sdataIn,
  input  logic              echoClkIn,
  output logic              sclkOut,
  output logic              busy,
  output logic [WORD_W-1:0] resultWord,
  output logic              resultValid,
  output logic              resultInvalid
);
  localparam int CNT_W = $clog2(SELF_BITS + 1);
  localparam int PH_W  = $clog2(SCLK_HALF_CYC);
  localparam logic [CNT_W-1:0] ECHO_N  = CNT_W'(ECHO_BITS);
  localparam logic [CNT_W-1:0] SELF_N  = CNT_W'(SELF_BITS);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SCLK_HALF_CYC - 1);

  logic                 active;
  logic                 sclkReg;
  logic [PH_W-1:0]      phase;
  logic [CNT_W-1:0]     clkLeft;
  logic [CNT_W-1:0]     rxCnt;
  logic                 rxDone;
  logic                 selfReg;
  logic                 staleReg;
  logic [SELF_BITS-1:0] shiftReg;
  logic                 echoS1, echoS2, echoS3;
  logic                 dataS1, dataS2;
  logic [WORD_W-1:0]    wordReg;
  logic                 validReg;
  logic                 invReg;

  logic [CNT_W-1:0]     nBits;
  logic                 tick, fallNow, echoRise, sampleEv, sampleBit, lastSample, hdrBad;
  logic [SELF_BITS-1:0] newShift;

  assign nBits      = selfReg ? SELF_N : ECHO_N;
  assign tick       = active && (clkLeft != '0) && (phase == PH_LAST);
  assign fallNow    = tick && sclkReg;
  assign echoRise   = echoS2 && !echoS3;
  assign sampleEv   = active && !rxDone && (selfReg ? fallNow : echoRise);
  assign sampleBit  = selfReg ? sdataIn : dataS2;
  assign newShift   = {shiftReg[SELF_BITS-2:0], sampleBit};
  assign lastSample = sampleEv && (rxCnt == nBits - 1'b1);
  assign hdrBad     = selfReg && (newShift[SELF_BITS-1:WORD_W] != HDR_PATTERN);

  // two-flop synchronizer for the returned clock and its data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echoS1 <= 1'b0; echoS2 <= 1'b0; echoS3 <= 1'b0;
      dataS1 <= 1'b0; dataS2 <= 1'b0;
    end else begin
      echoS1 <= echoClkIn; echoS2 <= echoS1; echoS3 <= echoS2;
      dataS1 <= sdataIn;   dataS2 <= dataS1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sclkReg  <= 1'b0;
      phase    <= '0;
      clkLeft  <= '0;
      rxCnt    <= '0;
      rxDone   <= 1'b0;
      selfReg  <= 1'b0;
      staleReg <= 1'b0;
      shiftReg <= '0;
      wordReg  <= '0;
      validReg <= 1'b0;
      invReg   <= 1'b0;
    end else begin
      validReg <= lastSample;
      if (ctl.readGo && !active) begin
        active   <= 1'b1;
        sclkReg  <= 1'b1;
        phase    <= '0;
        clkLeft  <= ctl.selfMode ? SELF_N : ECHO_N;
        rxCnt    <= '0;
        rxDone   <= 1'b0;
        selfReg  <= ctl.selfMode;
        staleReg <= ctl.stale;
        shiftReg <= '0;
      end else if (active) begin
        if (clkLeft != '0) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        if (tick) sclkReg <= ~sclkReg;
        if (fallNow) clkLeft <= clkLeft - 1'b1;
        if (sampleEv) begin
          shiftReg <= newShift;
          rxCnt    <= rxCnt + 1'b1;
        end
        if (lastSample) begin
          rxDone  <= 1'b1;
          wordReg <= newShift[WORD_W-1:0];
          invReg  <= staleReg || hdrBad;
        end
        if (clkLeft == '0 && rxDone) active <= 1'b0;
      end
    end
  end

  assign sclkOut       = sclkReg;
  assign busy          = active;
  assign resultWord    = wordReg;
  assign resultValid   = validReg;
  assign resultInvalid = invReg;

  AST_READ_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.readGo |-> !active); // R11

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclkReg); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid); // R9

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rxCnt <= nBits)); // R5
endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
  import sar_rd_pkg::*;
#(
  parameter int               CNV_HIGH_CYC   = 2,
  parameter int               MSB_WAIT_CYC   = 10,
  parameter int               MIN_PERIOD_CYC = 76,
  parameter int               MAX_IDLE_CYC   = 1000,
  parameter int               SCLK_HALF_CYC  = 2,
  parameter logic [HDR_W-1:0] HDR_PATTERN    = 2'b10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic              modeSel,
  input  logic              sdataIn,
  input  logic              echoClkIn,
  output logic              cnvOut,
  output logic              sclkOut,
  output logic [WORD_W-1:0] resultWord,
  output logic              resultValid,
  output logic              resultInvalid
);
  // longest burst plus synchronizer slack must fit in one period
  localparam int READ_SPAN = SELF_BITS * 2 * SCLK_HALF_CYC + 4;

  if (CNV_HIGH_CYC < 1 || CNV_HIGH_CYC >= MSB_WAIT_CYC) begin : g_bad_cnv
    $error("strobe width must be at least 1 and below the MSB wait");
  end
  if (SCLK_HALF_CYC < 2) begin : g_bad_div
    $error("serial clock half period must be at least 2 cycles");
  end
  if (MIN_PERIOD_CYC < READ_SPAN || MIN_PERIOD_CYC <= MSB_WAIT_CYC) begin : g_bad_min
    $error("minimum period too short for MSB wait or readout burst");
  end
  if (MAX_IDLE_CYC < MIN_PERIOD_CYC) begin : g_bad_max
    $error("idle limit must not be below the minimum period");
  end

  rdStrobeT ctl;
  logic     readerBusy;

  sar_rd_seq #(
    .CNV_HIGH_CYC  (CNV_HIGH_CYC),
    .MSB_WAIT_CYC  (MSB_WAIT_CYC),
    .MIN_PERIOD_CYC(MIN_PERIOD_CYC),
    .MAX_IDLE_CYC  (MAX_IDLE_CYC)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .modeSel   (modeSel),
    .readerBusy(readerBusy),
    .cnvOut    (cnvOut),
    .ctl       (ctl)
  );

  sar_rd_shift #(
    .SCLK_HALF_CYC(SCLK_HALF_CYC),
    .HDR_PATTERN  (HDR_PATTERN)
  ) i_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl          (ctl),
    .sdataIn      (sdataIn),
    .echoClkIn    (echoClkIn),
    .sclkOut      (sclkOut),
    .busy         (readerBusy),
    .resultWord   (resultWord),
    .resultValid  (resultValid),
    .resultInvalid(resultInvalid)
  );
endmodule

// File: tb/test_sar_read_ctrl.sv
module test_sar_read_ctrl;
  localparam int CNV_HI = 2;
  localparam int MSB_W  = 10;
  localparam int MIN_P  = 76;
  localparam int MAX_I  = 1000;

  logic clk = 1'b0, rst_n = 1'b0, startReq = 1'b0, modeSel = 1'b0;
  logic sdataIn, echoClkIn;
  logic cnvOut, sclkOut, resultValid, resultInvalid;
  logic [15:0] resultWord;

  always #5 clk = ~clk;

  sar_read_ctrl i_sar_read_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .modeSel(modeSel),
    .sdataIn(sdataIn), .echoClkIn(echoClkIn), .cnvOut(cnvOut), .sclkOut(sclkOut),
    .resultWord(resultWord), .resultValid(resultValid), .resultInvalid(resultInvalid));

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        modes [64];
  logic [15:0] words [64];
  logic [1:0]  hdrs  [64];
  int          riseT [64];
  bit          overlapAt [64];
  int nConv = 0, nValid = 0, nIssued = 0, lastBurst = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // converter model: returned clock lags by 5 ns, data moves 1 ns after a fall
  int   devIdx = 0, devK = 0;
  logic devBit = 1'b0;
  assign sdataIn = devBit;
  assign #5 echoClkIn = sclkOut;

  function automatic logic frameBit(input int k, input int idx);
    if (modes[k]) begin
      if (idx < 2) return hdrs[k][1-idx];
      return words[k][17-idx];
    end
    if (idx > 15) return 1'b0;
    return words[k][15-idx];
  endfunction

  always @(posedge sclkOut) devBit = frameBit(devK, devIdx);
  always @(negedge sclkOut) begin
    #1;
    devIdx++;
    if (devIdx == (modes[devK] ? 18 : 16)) begin
      devIdx = 0;
      devK++;
    end
    devBit = frameBit(devK, devIdx);
  end

  // port monitor
  logic prevCnv = 1'b0, prevSclk = 1'b0, prevValid = 1'b0;
  logic [15:0] prevWord = '0;
  logic prevInv = 1'b0;
  int hiLen = 0, burstRises = 0;
  always @(negedge clk) begin
    int k, n;
    bit expInv;
    if (rst_n) begin
      if (cnvOut) hiLen++;
      if (cnvOut && !prevCnv) begin
        riseT[nConv] = cyc;
        overlapAt[nConv] = (burstRises > 0);
        if (nConv > 0) chk(cyc - riseT[nConv-1] >= MIN_P, "R3 spacing", cyc - riseT[nConv-1], MIN_P);
        nConv++;
      end
      if (!cnvOut && prevCnv) begin
        chk(hiLen == CNV_HI, "R2 strobe width", hiLen, CNV_HI);
        hiLen = 0;
      end
      if (sclkOut && !prevSclk) begin
        if (burstRises == 0) chk(cyc - riseT[nValid] == MSB_W, "R4 msb wait", cyc - riseT[nValid], MSB_W);
        burstRises++;
      end
      if (resultValid) begin
        if (prevValid) chk(1'b0, "R9 pulse width", 2, 1);
        else begin
          k = nValid;
          n = modes[k] ? 18 : 16;
          chk(burstRises == n, "R5 clock count", burstRises, n);
          expInv = (k == 0) || (riseT[k] - riseT[k-1] > MAX_I) || (modes[k] && hdrs[k] != 2'b10);
          chk(resultWord == words[k], modes[k] ? "R7 own-clock word" : "R6 returned-clock word",
              int'(resultWord), int'(words[k]));
          chk(resultInvalid == expInv, "R8 invalid flag", int'(resultInvalid), int'(expInv));
          lastBurst = burstRises;
          burstRises = 0;
          nValid++;
        end
      end else if (resultWord != prevWord || resultInvalid != prevInv) begin
        chk(1'b0, "R9 hold", int'(resultWord), int'(prevWord));
      end
      prevCnv = cnvOut; prevSclk = sclkOut; prevValid = resultValid;
      prevWord = resultWord; prevInv = resultInvalid;
    end
  end

  task automatic issue(input logic m, input logic [15:0] w, input logic [1:0] h, input int spacing);
    int target;
    int k = nIssued;
    modes[k] = m; words[k] = w; hdrs[k] = h;
    target = (nConv == 0) ? cyc + 5 : riseT[nConv-1] + spacing - 1;
    while (cyc < target - 3) @(negedge clk);
    modeSel = m;
    while (cyc < target) @(negedge clk);
    startReq = 1'b1;
    nIssued++;
    @(negedge clk);
    startReq = 1'b0;
    while (nConv < nIssued) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (nValid < nIssued) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog R1 actual %0d expected %0d", nValid, nIssued);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      modes[i] = 1'b0; words[i] = '0; hdrs[i] = 2'b10; riseT[i] = 0; overlapAt[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnvOut == 1'b0, "R1 strobe", int'(cnvOut), 0);
    chk(sclkOut == 1'b0, "R1 sclk", int'(sclkOut), 0);
    chk(resultWord == 16'h0, "R1 word", int'(resultWord), 0);
    chk(resultValid == 1'b0, "R1 valid", int'(resultValid), 0);
    chk(resultInvalid == 1'b0, "R1 invalid", int'(resultInvalid), 0);

    // first conversion is stale (R8), returned-clock word (R6)
    issue(1'b0, 16'hA5C3, 2'b10, 0);
    drain();
    issue(1'b0, 16'h3C5A, 2'b10, 200);
    drain();
    // own-clock with good and bad header (R7)
    issue(1'b1, 16'hBEEF, 2'b10, 150);
    drain();
    issue(1'b1, 16'h1234, 2'b01, 150);
    drain();

    // early request held to the minimum period (R3)
    issue(1'b0, 16'h0F0F, 2'b10, 150);
    issue(1'b0, 16'hF00F, 2'b10, 30);
    chk(riseT[nConv-1] - riseT[nConv-2] == MIN_P, "R3 holdoff", riseT[nConv-1] - riseT[nConv-2], MIN_P);
    drain();

    // overlap: own-clock burst still running when next strobe rises (R11)
    issue(1'b1, 16'h8001, 2'b10, 150);
    issue(1'b1, 16'h7FFE, 2'b10, MIN_P);
    chk(overlapAt[nConv-1] == 1'b1, "R11 overlap", int'(overlapAt[nConv-1]), 1);
    drain();
    chk(nValid == nIssued, "R11 both results", nValid, nIssued);

    // idle limit boundary (R8)
    issue(1'b0, 16'h5555, 2'b10, MAX_I);
    drain();
    issue(1'b0, 16'hAAAA, 2'b10, MAX_I + 1);
    drain();

    // mode change during a readout is ignored (R10)
    issue(1'b0, 16'hC0DE, 2'b10, 120);
    modeSel = 1'b1;
    drain();
    chk(lastBurst == 16, "R10 mode frozen", lastBurst, 16);
    chk(resultWord == 16'hC0DE, "R10 word", int'(resultWord), 16'hC0DE);

    // sweep walking bits in both modes at varied spacings
    for (int i = 0; i < 16; i++) begin
      issue(i[0], 16'(1 << i) ^ 16'(i * 4099), 2'b10, 100 + i * 13);
    end
    drain();
    chk(nValid == nIssued, "R9 result count", nValid, nIssued);
    finishRun();
  end
endmodule